// File: doc/BRIEF.md
# Raster-Timed List Engine

This block is a small instruction processor that steps through a list of 32-bit commands held in memory and times each one against the position of the video beam. Each command is fetched as two 16-bit words through a synchronous read port. A register-write command drives an offset and a data word onto the display register bus. A hold command parks the engine until the beam reaches a masked target position. A conditional command steps over the following command when the beam has already passed a masked target.

The engine holds two list pointers. At every frame start it reloads its fetch address from the first pointer. Writing either of two strobe offsets sends it to the first or the second pointer at once. The pointers and strobes sit in the same offset space that the engine writes to. A list can therefore load the second pointer and jump through it, and it can change the list that later frames run, with no processor involved. A protection bit in a control register sets the lowest offset the list may write. A register-write command below that limit stops the engine until the next restart. The word pair FFFF/FFFE marks the end of the list for the frame.

Top module: `raster_seq`

## Requirements
- R1: After reset the engine is halted: it issues no memory read and no register write until a restart, and both pointers and the protection bit are zero.
- R2: A cycle with frame_start_i high reloads the fetch address from the first pointer. The first read is issued in the next cycle. This restart takes priority over every other action, including a register write in flight.
- R3: A first word with bit 0 clear is a register write. Word-one bits 8:1 give the even byte offset, and word two is the data. reg_we_o pulses for one cycle with the offset and the data. The first write of a list appears 4 cycles after the restart and each further write 4 cycles after the previous one.
- R4: A first word with bit 0 set is a beam compare. Word one holds the vertical target in bits 15:8 and the horizontal target in bits 7:1. Word two holds the vertical mask in bits 14:8 and the horizontal mask in bits 7:1; its bit 15 is ignored. The beam counts as reached when {vpos[7], vpos[6:0]&vmask, hpos[7:1]&hmask} >= {vt[7], vt[6:0]&vmask, ht&hmask}. Vertical bit 7 is never masked.
- R5: With word-two bit 0 clear the compare is a hold. The engine stalls without reading memory until the beam is reached. The next command's write appears 4 cycles after the first cycle in which the beam is reached.
- R6: With word-two bit 0 set the compare is conditional. If the beam is reached when it is evaluated, the next command is stepped over. Otherwise execution continues with it. Either way the engine does not stall.
- R7: The pair FFFF followed by FFFE stops the engine. No further reads or writes occur until a restart.
- R8: With the protection bit clear, a register write to an offset below 080h is not performed and stops the engine until a restart. Offsets of 080h and above are written.
- R9: Bit 1 of the control register at offset 02Eh is the protection bit. While it is set the lower limit is 040h instead of 080h.
- R10: The first pointer is loaded at 080h (upper bits) and 082h (bits 15:1). The second pointer is loaded at 084h and 086h in the same way. A load comes either from the host port or from the list's own writes, and a list write wins when both occur in the same cycle.
- R11: A write to 088h restarts fetching from the first pointer, and a write to 08Ah restarts from the second. The restart happens on the clock edge after the write is seen, whether the write comes from the host or from the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse at the first beam position of a frame |
| vpos_i | input | 8 | Vertical beam position |
| hpos_i | input | 8 | Horizontal beam position |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 9 | Host register byte offset |
| host_data_i | input | 16 | Host register write data |
| mem_rd_o | output | 1 | List memory read request |
| mem_addr_o | output | PTR_W | Byte address of the 16-bit word to read |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the request |
| reg_we_o | output | 1 | Register bus write strobe |
| reg_addr_o | output | 9 | Register bus byte offset |
| reg_data_o | output | 16 | Register bus write data |

## Verification
The bench drives a beam of 16 lines by 64 positions and runs a new list in each frame. Hold commands are swept over a grid of vertical and horizontal targets, including targets reached too late to finish inside the frame, and the bench predicts the cycle of the following write from the compare rule. This separates an off-by-one in the fetch pipeline from a wrong compare order. Further masked cases check that the masks, and the unmasked vertical top bit, are honoured. Conditional commands are evaluated on both sides of a horizontal boundary. Lists that write near the protection limits, change the pointers and pulse the strobes show whether the engine stops, jumps or continues at the expected beam position.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {S_HALT, S_RD1, S_LD1, S_LD2, S_EXE, S_WAIT} rseq_state_e;

  localparam int          BEAM_W     = 8;
  localparam int          NUM_PTR    = 2;
  localparam logic [8:0]  OFF_CTRL   = 9'h02E;
  localparam logic [8:0]  OFF_P1_HI  = 9'h080;
  localparam logic [8:0]  OFF_JMP1   = 9'h088;
  localparam logic [8:0]  LIM_SAFE   = 9'h080;
  localparam logic [8:0]  LIM_DANGER = 9'h040;
  localparam logic [15:0] END_W1     = 16'hFFFF;
  localparam logic [15:0] END_W2     = 16'hFFFE;

  // word-select of pointer g upper half; lower half is +1 word
  function automatic logic [7:0] ptr_hi_sel(int g);
    return OFF_P1_HI[8:1] + 8'(2 * g);
  endfunction

  function automatic logic [7:0] jmp_sel(int g);
    return OFF_JMP1[8:1] + 8'(g);
  endfunction
endpackage

// File: rtl/rseq_beam_cmp.sv
module rseq_beam_cmp
  import rseq_pkg::*;
(
  input  logic [BEAM_W-1:0] vpos_i,
  input  logic [BEAM_W-1:0] hpos_i,
  input  logic [15:0]       pos_w_i,
  input  logic [15:0]       mask_w_i,
  output logic              hit_o
);
  logic [6:0]  vmask, hmask;
  logic [15:0] beam_key, tgt_key;

  assign vmask    = mask_w_i[14:8];
  assign hmask    = mask_w_i[7:1];
  // vertical top bit never masked
  assign beam_key = {vpos_i[7], vpos_i[6:0] & vmask, hpos_i[7:1] & hmask};
  assign tgt_key  = {pos_w_i[15], pos_w_i[14:8] & vmask, pos_w_i[7:1] & hmask};
  assign hit_o    = beam_key >= tgt_key;
endmodule

// File: rtl/rseq_ctl_regs.sv
module rseq_ctl_regs
  import rseq_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [8:0]       wr_addr_i,
  input  logic [15:0]      wr_data_i,
  output logic [PTR_W-1:0] ptr1_o,
  output logic [PTR_W-1:0] ptr2_o,
  output logic             danger_o,
  output logic             jump1_o,
  output logic             jump2_o
);
  localparam int HI_W = PTR_W - 16;

  logic [PTR_W-1:0]   ptr_q [NUM_PTR];
  logic [NUM_PTR-1:0] jump;
  logic               danger_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_PTR; g++) ptr_q[g] <= '0;
      danger_q <= 1'b0;
    end else if (wr_en_i) begin
      for (int g = 0; g < NUM_PTR; g++) begin
        if (wr_addr_i[8:1] == ptr_hi_sel(g))
          ptr_q[g][PTR_W-1:16] <= wr_data_i[HI_W-1:0];
        if (wr_addr_i[8:1] == ptr_hi_sel(g) + 8'd1)
          ptr_q[g][15:0] <= {wr_data_i[15:1], 1'b0};
      end
      if (wr_addr_i[8:1] == OFF_CTRL[8:1]) danger_q <= wr_data_i[1];
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_PTR; g++)
      jump[g] = wr_en_i && (wr_addr_i[8:1] == jmp_sel(g));
  end

  assign ptr1_o   = ptr_q[0];
  assign ptr2_o   = ptr_q[1];
  assign danger_o = danger_q;
  assign jump1_o  = jump[0];
  assign jump2_o  = jump[1];

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(ptr_q[0]) && $stable(ptr_q[1]))); // R10
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import rseq_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [7:0]       vpos_i,
  input  logic [7:0]       hpos_i,
  input  logic             host_we_i,
  input  logic [8:0]       host_addr_i,
  input  logic [15:0]      host_data_i,
  output logic             mem_rd_o,
  output logic [PTR_W-1:0] mem_addr_o,
  input  logic [15:0]      mem_rdata_i,
  output logic             reg_we_o,
  output logic [8:0]       reg_addr_o,
  output logic [15:0]      reg_data_o
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(2);

  rseq_state_e      st_q;
  logic [PTR_W-1:0] pc_q, ptr1, ptr2, new_pc;
  logic [15:0]      w1_q, w2_q;
  logic             danger, jump1, jump2, hit, restart;
  logic             is_move, is_end, is_skip, blocked, do_move;
  logic             wr_en;
  logic [8:0]       wr_addr, move_off;
  logic [15:0]      wr_data;

  // own writes take precedence over host writes
  assign wr_en   = reg_we_o | host_we_i;
  assign wr_addr = reg_we_o ? reg_addr_o : host_addr_i;
  assign wr_data = reg_we_o ? reg_data_o : host_data_i;

  rseq_ctl_regs #(.PTR_W(PTR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .ptr1_o    (ptr1),
    .ptr2_o    (ptr2),
    .danger_o  (danger),
    .jump1_o   (jump1),
    .jump2_o   (jump2)
  );

  rseq_beam_cmp u_cmp (
    .vpos_i   (vpos_i),
    .hpos_i   (hpos_i),
    .pos_w_i  (w1_q),
    .mask_w_i (w2_q),
    .hit_o    (hit)
  );

  assign move_off = {w1_q[8:1], 1'b0};
  assign is_move  = !w1_q[0];
  assign is_end   = (w1_q == END_W1) && (w2_q == END_W2);
  assign is_skip  = w2_q[0];
  assign blocked  = move_off < (danger ? LIM_DANGER : LIM_SAFE);
  assign restart  = frame_start_i | jump1 | jump2;
  assign new_pc   = (frame_start_i | jump1) ? ptr1 : ptr2;
  assign do_move  = (st_q == S_EXE) && is_move && !blocked && !restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_HALT;
      pc_q <= '0;
      w1_q <= '0;
      w2_q <= '0;
    end else if (restart) begin
      st_q <= S_RD1;
      pc_q <= new_pc;
    end else begin
      unique case (st_q)
        S_RD1: begin
          pc_q <= pc_q + STEP;
          st_q <= S_LD1;
        end
        S_LD1: begin
          w1_q <= mem_rdata_i;
          pc_q <= pc_q + STEP;
          st_q <= S_LD2;
        end
        S_LD2: begin
          w2_q <= mem_rdata_i;
          st_q <= S_EXE;
        end
        S_EXE: begin
          if (is_move)      st_q <= blocked ? S_HALT : S_RD1;
          else if (is_end)  st_q <= S_HALT;
          else if (is_skip) begin
            if (hit) pc_q <= pc_q + STEP + STEP;
            st_q <= S_RD1;
          end else          st_q <= hit ? S_RD1 : S_WAIT;
        end
        S_WAIT: if (hit) st_q <= S_RD1;
        default: st_q <= S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_we_o   <= 1'b0;
      reg_addr_o <= '0;
      reg_data_o <= '0;
    end else begin
      reg_we_o <= do_move;
      if (do_move) begin
        reg_addr_o <= move_off;
        reg_data_o <= w2_q;
      end
    end
  end

  assign mem_rd_o   = (st_q == S_RD1) || (st_q == S_LD1);
  assign mem_addr_o = pc_q;

  AST_MOVE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_addr_o >= ($past(danger) ? LIM_DANGER : LIM_SAFE))); // R8
  AST_RESTART_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (mem_rd_o && mem_addr_o == $past(ptr1))); // R2
  AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT) |-> (!mem_rd_o && !reg_we_o)); // R5
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R3
endmodule

// File: tb/test_raster_seq.sv
module test_raster_seq;
  localparam int PTR_W = 20;
  localparam int HTOT  = 64;
  localparam int VTOT  = 16;
  localparam int FRAME = HTOT * VTOT;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             frame_start_i = 1'b0;
  logic [7:0]       vpos_i = '0, hpos_i = '0;
  logic             host_we_i = 1'b0;
  logic [8:0]       host_addr_i = '0;
  logic [15:0]      host_data_i = '0;
  logic             mem_rd_o;
  logic [PTR_W-1:0] mem_addr_o;
  logic [15:0]      mem_rdata_i = '0;
  logic             reg_we_o;
  logic [8:0]       reg_addr_o;
  logic [15:0]      reg_data_o;

  raster_seq #(.PTR_W(PTR_W)) i_raster_seq (.*);

  initial forever #4 clk_i = ~clk_i;

  logic [15:0] mem [256];
  always @(posedge clk_i) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[8:1]];

  int nchk = 0, nfail = 0;
  int lin = 0, frame_cnt = 0;
  int nw = 0, lr = -1, frl = -1, fra = 0;
  int wl [16];
  int wa [16];
  int wd [16];
  int pw = 0, plr = -1, pfrl = -1, pfra = 0;
  int pl [16];
  int pa [16];
  int pd [16];

  // beam generator and output logger: sample first, then advance the beam
  initial forever begin
    @(negedge clk_i);
    if (reg_we_o && nw < 16) begin
      wl[nw] = lin; wa[nw] = int'(reg_addr_o); wd[nw] = int'(reg_data_o); nw++;
    end
    if (mem_rd_o) begin
      lr = lin;
      if (frl < 0) begin frl = lin; fra = int'(mem_addr_o); end
    end
    lin++;
    if (lin == FRAME) begin
      lin = 0; frame_cnt++;
      pw = nw; plr = lr; pfrl = frl; pfra = fra;
      for (int i = 0; i < 16; i++) begin pl[i] = wl[i]; pa[i] = wa[i]; pd[i] = wd[i]; end
      nw = 0; lr = -1; frl = -1; fra = 0;
    end
    frame_start_i = (lin == 0);
    vpos_i = 8'(lin / HTOT);
    hpos_i = 8'(lin % HTOT);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  task automatic put_move(input int idx, input logic [8:0] off, input logic [15:0] d);
    mem[idx] = {7'd0, off}; mem[idx+1] = d;
  endtask
  task automatic put_end(input int idx);
    mem[idx] = 16'hFFFF; mem[idx+1] = 16'hFFFE;
  endtask
  task automatic put_cmp(input int idx, input logic [7:0] vt, input logic [6:0] ht,
                         input logic [6:0] vm, input logic [6:0] hm, input bit skip);
    mem[idx] = {vt, ht, 1'b1}; mem[idx+1] = {1'b0, vm, hm, skip};
  endtask
  task automatic host_wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk_i);
    host_addr_i = a; host_data_i = d; host_we_i = 1'b1;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask
  task automatic do_frame();
    int fc;
    fc = frame_cnt;
    wait (frame_cnt == fc + 1);
    wait (frame_cnt == fc + 2);
  endtask

  function automatic bit reached(int l, logic [7:0] vt, logic [6:0] ht, logic [6:0] vm, logic [6:0] hm);
    logic [7:0] v, h;
    v = 8'(l / HTOT); h = 8'(l % HTOT);
    return {v[7], v[6:0] & vm, h[7:1] & hm} >= {vt[7], vt[6:0] & vm, ht & hm};
  endfunction
  function automatic int first_hit(logic [7:0] vt, logic [6:0] ht, logic [6:0] vm, logic [6:0] hm);
    for (int l = 4; l < FRAME; l++) if (reached(l, vt, ht, vm, hm)) return l;
    return -1;
  endfunction

  task automatic wait_case(input int id, input logic [7:0] vt, input logic [6:0] ht,
                           input logic [6:0] vm, input logic [6:0] hm, input string req);
    int l;
    put_cmp(0, vt, ht, vm, hm, 1'b0);
    put_move(2, 9'h180, 16'(id));
    put_end(4);
    do_frame();
    l = first_hit(vt, ht, vm, hm);
    if (l >= 0 && l + 4 <= FRAME - 1)
      chk(pw == 1 && pl[0] == l + 4 && pd[0] == id, req, pl[0], l + 4);
    else
      chk(pw == 0, req, pw, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: halted after reset
    repeat (6) @(negedge clk_i);
    chk(!mem_rd_o, "R1 no read", int'(mem_rd_o), 0);
    chk(!reg_we_o, "R1 no write", int'(reg_we_o), 0);

    // R3/R2/R7: plain write list from pointer 0
    put_move(0, 9'h100, 16'h1234);
    put_move(2, 9'h102, 16'h5678);
    put_move(4, 9'h1FE, 16'h9ABC);
    put_end(6);
    do_frame();
    chk(pfrl == 0 && pfra == 0, "R2 R1 first read", pfrl, 0);
    chk(pw == 3, "R3 write count", pw, 3);
    chk(pa[0] == 'h100 && pd[0] == 'h1234 && pl[0] == 4, "R3 write0", pl[0], 4);
    chk(pa[1] == 'h102 && pd[1] == 'h5678 && pl[1] == 8, "R3 write1", pl[1], 8);
    chk(pa[2] == 'h1FE && pd[2] == 'h9ABC && pl[2] == 12, "R3 write2", pl[2], 12);
    chk(plr == 13, "R7 end stops fetch", plr, 13);

    // R5: hold sweep over target grid, full masks
    for (int v = 1; v < 16; v += 2)
      for (int c = 0; c < 3; c++)
        wait_case(v * 4 + c, 8'(v), (c == 0) ? 7'd0 : (c == 1) ? 7'd13 : 7'd31,
                  7'h7F, 7'h7F, "R5 hold sweep");
    // R4: mask behaviour
    wait_case(100, 8'd6, 7'd20, 7'h7F, 7'h00, "R4 hmask off");
    wait_case(101, 8'd5, 7'd0, 7'h7C, 7'h7F, "R4 vmask low");
    wait_case(102, 8'h80, 7'd0, 7'h7F, 7'h7F, "R4 vbit7 unmasked");
    wait_case(103, 8'h80, 7'd0, 7'h00, 7'h00, "R4 vbit7 no mask");
    wait_case(104, 8'd0, 7'd0, 7'h00, 7'h00, "R4 zero masks");

    // R6: conditional step, evaluated with beam at h=4
    put_cmp(0, 8'd0, 7'd2, 7'h7F, 7'h7F, 1'b1);
    put_move(2, 9'h180, 16'h0001);
    put_move(4, 9'h182, 16'h0002);
    put_end(6);
    do_frame();
    chk(pw == 1 && pa[0] == 'h182 && pl[0] == 8, "R6 step taken", pa[0], 'h182);
    put_cmp(0, 8'd0, 7'd3, 7'h7F, 7'h7F, 1'b1);
    do_frame();
    chk(pw == 2 && pa[0] == 'h180 && pl[0] == 8 && pl[1] == 12, "R6 step not taken", pw, 2);
    put_cmp(0, 8'd1, 7'd0, 7'h7F, 7'h7F, 1'b1);
    do_frame();
    chk(pw == 2, "R6 vertical not reached", pw, 2);

    // R8: protection clear
    put_move(0, 9'h08C, 16'h0001);
    put_move(2, 9'h07E, 16'h0002);
    put_move(4, 9'h180, 16'h0003);
    put_end(6);
    do_frame();
    chk(pw == 1 && pa[0] == 'h08C, "R8 below limit not written", pw, 1);
    chk(plr == 5, "R8 engine stops", plr, 5);

    // R9: protection set
    host_wr(9'h02E, 16'h0002);
    put_move(0, 9'h040, 16'h0004);
    put_move(2, 9'h03E, 16'h0005);
    put_move(4, 9'h180, 16'h0006);
    do_frame();
    chk(pw == 1 && pa[0] == 'h040, "R9 limit 040", pa[0], 'h040);
    put_move(0, 9'h07E, 16'h0007);
    put_end(2);
    do_frame();
    chk(pw == 1 && pa[0] == 'h07E && pd[0] == 7, "R9 07E allowed", pa[0], 'h07E);
    host_wr(9'h02E, 16'h0000);

    // R10: host loads first pointer
    put_move(128, 9'h190, 16'hBEEF);
    put_end(130);
    host_wr(9'h082, 16'h0100);
    do_frame();
    chk(pfra == 'h100 && pw == 1 && pa[0] == 'h190 && pl[0] == 4, "R10 low half", pfra, 'h100);
    host_wr(9'h080, 16'h0001);
    do_frame();
    chk(pfra == 'h10100, "R10 high half", pfra, 'h10100);
    host_wr(9'h080, 16'h0000);
    host_wr(9'h082, 16'h0000);

    // R11/R10: list loads second pointer and jumps through it
    put_move(0, 9'h084, 16'h0000);
    put_move(2, 9'h086, 16'h0100);
    put_move(4, 9'h08A, 16'h0000);
    put_end(6);
    do_frame();
    chk(pw == 4 && pa[3] == 'h190 && pl[3] == 17, "R11 list jump second", pl[3], 17);

    // R11: host strobe restarts from first pointer mid-frame
    put_move(0, 9'h1A0, 16'h0011);
    put_end(2);
    begin
      int fc;
      fc = frame_cnt;
      wait (frame_cnt == fc + 1);
      wait (lin == 499);
      host_addr_i = 9'h088; host_data_i = '0; host_we_i = 1'b1;
      @(negedge clk_i);
      host_we_i = 1'b0;
      wait (frame_cnt == fc + 2);
    end
    chk(pw == 2 && pl[0] == 4 && pl[1] == 503, "R11 host strobe", pl[1], 503);

    finish_run();
  end
endmodule